// File: doc/BRIEF.md
# Accumulator Operate Unit

This unit carries out one operate-class instruction on a 12-bit accumulator and a one-bit link register. The instruction word holds no operand address. Instead, each bit enables one single-register sub-operation: clear, complement, increment, rotate through the link, or a test that asks the sequencer to skip the next instruction. Any mix of these sub-operations can share one word.

Enabled sub-operations run in a fixed order, with one clock phase for each group. Clears run first, then complements, then the increment, and last the rotate together with the zero test. A sequencer pulses `start` with the word. When the sequence ends, the unit pulses `done`. In that same cycle it also pulses `skip` if the skip is needed, and `illegal` if the word asked for both rotate directions. The unit does not fetch instructions and has no program counter.

Top module: `acc_opr_unit`

## Requirements
- R1: While reset is held and after it is released, `acc`, `link`, `done`, `skip` and `illegal` are all zero.
- R2: In the first phase, instr[0] clears `acc` and instr[1] clears `link`. Both take effect before any complement.
- R3: In the second phase, instr[2] inverts every bit of `acc` and instr[3] inverts `link`. Both act on the values left by the clears.
- R4: In the third phase, instr[4] adds one to `acc` modulo 4096. A carry out of bit 11 inverts `link`.
- R5: In the fourth phase, instr[5] rotates the 13-bit ring {link, acc} left and instr[6] rotates it right. Bit 11 moves into the link on a left rotate, and bit 0 moves into the link on a right rotate. instr[7] set selects two places, and clear selects one place.
- R6: A word with both instr[5] and instr[6] set leaves `acc` and `link` unrotated and raises `illegal` for exactly the cycle of `done`.
- R7: When instr[8] is set and the final `acc` is zero, `skip` is high for exactly the cycle of `done`. Otherwise `skip` stays low.
- R8: If `start` is sampled at rising edge k, `done` is high from edge k+4 to edge k+5 only. `acc` and `link` hold their final values from edge k+4 on.
- R9: A `start` pulse that arrives while a sequence is in progress is ignored. It neither changes the result nor extends the sequence.
- R10: Starting from any state, word 0x0BB (clear both, complement link, increment, rotate left two places) leaves `acc` = 6 and `link` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 9 | Operate word, one enable bit for each sub-operation |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| skip | output | 1 | One-cycle request to skip the next instruction |
| done | output | 1 | One-cycle end-of-instruction strobe |
| illegal | output | 1 | One-cycle flag for a word that selects both rotate directions |

## Verification
The link can be changed by two different phases in one instruction. The complement-link phase can invert it, and the increment carry can invert it again before the rotate moves an accumulator bit into it. The same ordering risk applies to the zero test and the rotate: the zero test must see the rotated value. These collisions are provoked by running all 512 instruction words back to back, so that the state each word leaves, including the all-ones accumulator, becomes the start state of the next word. A second pass visits the words in a scrambled order. After every word, a bench model that applies the phases one at a time judges `acc`, `link`, `skip`, `illegal` and the cycle of `done`.

// File: rtl/acc_opr_pkg.sv
package acc_opr_pkg;
  localparam int INSTR_W = 9;
  localparam int B_CLR_ACC  = 0;
  localparam int B_CLR_LINK = 1;
  localparam int B_CMP_ACC  = 2;
  localparam int B_CMP_LINK = 3;
  localparam int B_INC      = 4;
  localparam int B_ROT_L    = 5;
  localparam int B_ROT_R    = 6;
  localparam int B_ROT_TWO  = 7;
  localparam int B_SKIP_Z   = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CLR, PH_CMP, PH_INC, PH_ROT
  } phaseT;

  typedef struct packed {
    logic load;
    logic doClr;
    logic doCmp;
    logic doInc;
    logic doRot;
  } strobeT;
endpackage

// File: rtl/acc_opr_ctrl.sv
module acc_opr_ctrl
  import acc_opr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output strobeT strobes,
  output logic   done
);
  phaseT phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (phase == PH_ROT);
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_CLR;
        PH_CLR:  phase <= PH_CMP;
        PH_CMP:  phase <= PH_INC;
        PH_INC:  phase <= PH_ROT;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load  = (phase == PH_IDLE) && start;
    strobes.doClr = (phase == PH_CLR);
    strobes.doCmp = (phase == PH_CMP);
    strobes.doInc = (phase == PH_INC);
    strobes.doRot = (phase == PH_ROT);
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CLR) |=> (phase == PH_CMP));
endmodule

// File: rtl/acc_opr_dp.sv
module acc_opr_dp
  import acc_opr_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [INSTR_W-1:0] instr,
  output logic [DW-1:0]      acc,
  output logic               link,
  output logic               skip,
  output logic               illegal
);
  localparam int RW = DW + 1;

  logic [INSTR_W-1:0] ir;
  logic [DW:0]        incSum;
  logic [RW-1:0]      ring;
  logic [2*RW-1:0]    ringL, ringR;
  logic [RW-1:0]      rotOut;
  logic               bothDir;
  int                 shamt;

  always_comb begin
    incSum  = {1'b0, acc} + {{DW{1'b0}}, 1'b1};
    ring    = {link, acc};
    shamt   = ir[B_ROT_TWO] ? 2 : 1;
    ringL   = {ring, ring} << shamt;
    ringR   = {ring, ring} >> shamt;
    bothDir = ir[B_ROT_L] && ir[B_ROT_R];
    if (bothDir)           rotOut = ring;
    else if (ir[B_ROT_L])  rotOut = ringL[2*RW-1:RW];
    else if (ir[B_ROT_R])  rotOut = ringR[RW-1:0];
    else                   rotOut = ring;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ir      <= '0;
      acc     <= '0;
      link    <= 1'b0;
      skip    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      skip    <= 1'b0;
      illegal <= 1'b0;
      if (strobes.load) ir <= instr;
      if (strobes.doClr) begin
        if (ir[B_CLR_ACC])  acc  <= '0;
        if (ir[B_CLR_LINK]) link <= 1'b0;
      end
      if (strobes.doCmp) begin
        if (ir[B_CMP_ACC])  acc  <= ~acc;
        if (ir[B_CMP_LINK]) link <= ~link;
      end
      if (strobes.doInc && ir[B_INC]) begin
        acc  <= incSum[DW-1:0];
        link <= link ^ incSum[DW];
      end
      if (strobes.doRot) begin
        link    <= rotOut[RW-1];
        acc     <= rotOut[DW-1:0];
        skip    <= ir[B_SKIP_Z] && (rotOut[DW-1:0] == '0);
        illegal <= bothDir;
      end
    end
  end

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doInc && ir[B_INC]) |=> (acc == $past(acc) + 1'b1));

  // R2
  clr_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doClr && ir[B_CLR_ACC]) |=> (acc == '0));

  // R6
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doRot && bothDir) |=> ($stable(acc) && $stable(link)));
endmodule

// File: rtl/acc_opr_unit.sv
module acc_opr_unit
  import acc_opr_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic [DW-1:0]      acc,
  output logic               link,
  output logic               skip,
  output logic               done,
  output logic               illegal
);
  strobeT strobes;

  acc_opr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .done(done)
  );

  acc_opr_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instr(instr),
    .acc(acc), .link(link), .skip(skip), .illegal(illegal)
  );

  // R7
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> (done && acc == '0));

  // R6
  illegal_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);
endmodule

// File: tb/acc_opr_unit_bench.sv
module acc_opr_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  instr = '0;
  logic [11:0] acc;
  logic        link, skip, done, illegal;

  int checks = 0;
  int errors = 0;
  logic [11:0] mAcc = '0;
  logic        mLink = 1'b0;
  logic        mSkip, mIll;

  always #2.5 clk = ~clk;

  acc_opr_unit u_acc_opr_unit (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .acc(acc), .link(link), .skip(skip), .done(done), .illegal(illegal)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [8:0] w);
    logic [12:0] r;
    int n;
    if (w[0]) mAcc = '0;
    if (w[1]) mLink = 1'b0;
    if (w[2]) mAcc = ~mAcc;
    if (w[3]) mLink = ~mLink;
    if (w[4]) begin
      if (mAcc == 12'hFFF) mLink = ~mLink;
      mAcc = mAcc + 12'd1;
    end
    mIll = w[5] && w[6];
    n = w[7] ? 2 : 1;
    r = {mLink, mAcc};
    if (!mIll) begin
      for (int i = 0; i < n; i++) begin
        if (w[5]) r = {r[11:0], r[12]};
        else if (w[6]) r = {r[0], r[12:1]};
      end
    end
    {mLink, mAcc} = r;
    mSkip = w[8] && (mAcc == 12'd0);
  endtask

  task automatic run(input logic [8:0] w, input logic poke);
    @(negedge clk);
    start = 1'b1; instr = w;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      start = 1'b1; instr = ~w;
      @(posedge clk); #1;
      start = 1'b0;
      @(posedge clk); #1;
    end else begin
      repeat (3) @(posedge clk); #1;
    end
    // R8 no early done
    chk(done == 1'b0, "R8 early", done, 0);
    model(w);
    @(posedge clk); #1;
    chk(done == 1'b1, "R8 done", done, 1);
    chk(acc == mAcc, "R2 R3 R4 R5 acc", acc, mAcc);
    chk(link == mLink, "R4 R5 link", link, mLink);
    chk(skip == mSkip, "R7 skip", skip, mSkip);
    chk(illegal == mIll, "R6 illegal", illegal, mIll);
    @(posedge clk); #1;
    chk(done == 1'b0 && skip == 1'b0 && illegal == 1'b0, "R8 pulse", {done, skip, illegal}, 0);
    chk(acc == mAcc && link == mLink, "R9 hold", {link, acc}, {mLink, mAcc});
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R1
    chk(acc == 0 && link == 0 && done == 0 && skip == 0 && illegal == 0,
        "R1 reset", {link, acc, done, skip, illegal}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(acc == 0 && link == 0 && done == 0, "R1 after", {link, acc, done}, 0);
    // R10
    run(9'h0BB, 1'b0);
    chk(acc == 12'd6 && link == 1'b0, "R10 six", {link, acc}, 6);
    // all words in order
    for (int k = 0; k < 512; k++) run(9'(k), 1'b0);
    // scrambled order
    for (int k = 0; k < 512; k++) run(9'((k * 37 + 11) % 512), 1'b0);
    // R9 start while busy
    for (int k = 0; k < 64; k++) run(9'((k * 53 + 5) % 512), 1'b1);
    // R7 skip on zero after full ones wrap
    run(9'h005, 1'b0);
    run(9'h110, 1'b0);
    chk(skip == 1'b0 && acc == 0, "R7 zero reached", {skip, acc}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule